// File: doc/BRIEF.md
# Two-Omega Two-Flip Bit Permuter

A combinational unit that rearranges the bits of a data word through four fixed network stages: two identical omega stages followed by two identical flip stages. Each operation switches on exactly two of the four stages. A stage that is switched off hands its input to the next stage unchanged. A stage that is switched on routes its bits through its fixed shuffle wiring, and a control bit for each adjacent bit pair can exchange the two bits of that pair. Every output bit of a stage therefore picks one of three sources: the bit at the same position when the stage is off, or one of the two bits of a pair in the shuffle wiring.

A complete omega network followed by a complete flip network can realise any permutation of the word. With this unit, software reaches an arbitrary permutation of an n-bit word by issuing log2(n) operations in sequence, each one naming two stages and giving their control bits. The datapath keeps four stages for any word width, because repeated stages of one kind share the same wiring. Computing the control words for a target permutation is left to software.

Top module: `omega_flip_permuter`

## Requirements
- R1: When `stage_en` does not have exactly two bits set (this covers 0, 1, 3 and 4 set bits), `data_out` equals `data_in`.
- R2: Stage order is fixed. `stage_en` bit 0 selects the first omega stage, bit 1 the second omega stage, bit 2 the first flip stage and bit 3 the second flip stage, and data passes through the stages in that order. When `ctrl_in` is all zero, the output is only the composition of the shuffles of the enabled stages.
- R3: The perfect shuffle of an n-bit word moves bit i to position rotl(i), which is i rotated left by one inside log2(n) bits. An enabled omega stage applies the shuffle first. It then exchanges the bits at positions 2k and 2k+1 when bit k of its configuration half is 1.
- R4: An enabled flip stage first applies the same pair exchanges, with bit k controlling positions 2k and 2k+1. It then applies the inverse shuffle, which moves bit i to rotr(i).
- R5: The first enabled stage in stage order takes its configuration from `ctrl_in[WIDTH/2-1:0]`. The second enabled stage takes it from `ctrl_in[WIDTH-1:WIDTH/2]`.
- R6: The output is always a permutation of the input, so the number of ones is preserved.
- R7: When one omega stage and one flip stage are enabled and both halves of `ctrl_in` are equal, the flip stage undoes the omega stage and `data_out` equals `data_in`.
- R8: The output depends only on the present inputs. It settles in the same cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | WIDTH | Word to be permuted |
| ctrl_in | input | WIDTH | Two configuration halves: the lower half for the first enabled stage, the upper half for the second |
| stage_en | input | 4 | One enable bit per stage, in stage order; exactly two must be set |
| data_out | output | WIDTH | Permuted word |

## Verification
An 8-bit copy of the unit is swept over every enable value and every control word, with each one-hot data word applied. A one-hot word follows a single bit through the stages, so it tells apart permutations that a dense pattern could hide. Zero control words isolate the shuffle composition of each stage pair. Single-bit control words identify which half configures which stage, and which pair each bit exchanges. On the 64-bit unit, mixed data and control patterns check the output against the model. Control words with equal halves on an omega-plus-flip pair check that the flip stage undoes the omega stage. The ones count is compared for every applied pattern.

// File: rtl/omega_flip_permuter.sv
module omega_flip_permuter #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] data_in,
  input  logic [WIDTH-1:0] ctrl_in,
  input  logic [3:0]       stage_en,
  output logic [WIDTH-1:0] data_out
);

  localparam int LG     = $clog2(WIDTH);
  localparam int HALF   = WIDTH / 2;
  localparam int STAGES = 4;
  localparam int N_OMEGA = 2;

  logic             two_set;
  logic [3:0]       act;
  logic [WIDTH-1:0] link [0:STAGES];

  assign two_set  = ($countones(stage_en) == 2);
  assign act      = two_set ? stage_en : 4'b0000;
  assign link[0]  = data_in;
  assign data_out = link[STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic             use_hi;
    logic [HALF-1:0]  cfg;
    logic [WIDTH-1:0] nxt;

    if (s == 0) begin : g_first
      assign use_hi = 1'b0;
    end else begin : g_later
      assign use_hi = |act[s-1:0];
    end

    assign cfg         = use_hi ? ctrl_in[WIDTH-1:HALF] : ctrl_in[HALF-1:0];
    assign link[s+1]   = nxt;

    for (genvar j = 0; j < WIDTH; j++) begin : g_bit
      localparam int ROL_J  = ((j << 1) | (j >> (LG - 1))) & (WIDTH - 1);
      localparam int ROR_J  = (j >> 1) | ((j & 1) << (LG - 1));
      localparam int ROR_J1 = ((j ^ 1) >> 1) | (((j ^ 1) & 1) << (LG - 1));

      if (s < N_OMEGA) begin : g_omega
        assign nxt[j] = !act[s]        ? link[s][j] :
                        cfg[j >> 1]    ? link[s][ROR_J1] : link[s][ROR_J];
      end else begin : g_flip
        assign nxt[j] = !act[s]           ? link[s][j] :
                        cfg[ROL_J >> 1]   ? link[s][ROL_J ^ 1] : link[s][ROL_J];
      end
    end
  end

endmodule

// File: rtl/omega_flip_permuter_chk.sv
module omega_flip_permuter_chk #(
  parameter int WIDTH = 64
) (
  input logic [WIDTH-1:0] data_in,
  input logic [WIDTH-1:0] ctrl_in,
  input logic [3:0]       stage_en,
  input logic [WIDTH-1:0] data_out
);

  localparam int LG   = $clog2(WIDTH);
  localparam int HALF = WIDTH / 2;

  function automatic logic [WIDTH-1:0] unshuffle2(input logic [WIDTH-1:0] x);
    logic [WIDTH-1:0] y;
    for (int i = 0; i < WIDTH; i++) begin
      int r1;
      int r2;
      r1 = (i >> 1) | ((i & 1) << (LG - 1));
      r2 = (r1 >> 1) | ((r1 & 1) << (LG - 1));
      y[r2] = x[i];
    end
    return y;
  endfunction

  logic one_omega_one_flip;
  assign one_omega_one_flip = ($countones(stage_en[1:0]) == 1) &&
                              ($countones(stage_en[3:2]) == 1);

  always_comb begin
    // R1
    if ($countones(stage_en) != 2)
      pass_all_chk: assert (data_out == data_in);
    // R6
    ones_kept_chk: assert ($countones(data_out) == $countones(data_in));
    // R7
    if (one_omega_one_flip && (ctrl_in[HALF-1:0] == ctrl_in[WIDTH-1:HALF]))
      undo_pair_chk: assert (data_out == data_in);
    // R2
    if (stage_en == 4'b1100 && ctrl_in == '0)
      flip_shuffles_chk: assert (data_out == unshuffle2(data_in));
  end

endmodule

bind omega_flip_permuter omega_flip_permuter_chk #(.WIDTH(WIDTH)) u_chk (
  .data_in  (data_in),
  .ctrl_in  (ctrl_in),
  .stage_en (stage_en),
  .data_out (data_out)
);

// File: tb/omega_flip_permuter_bench.sv
module omega_flip_permuter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [63:0] din64, ctl64, dout64;
  logic [3:0]  en64;
  logic [7:0]  din8, ctl8, dout8;
  logic [3:0]  en8;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  omega_flip_permuter #(.WIDTH(64)) u_omega_flip_permuter (
    .data_in(din64), .ctrl_in(ctl64), .stage_en(en64), .data_out(dout64));
  omega_flip_permuter #(.WIDTH(8)) u_omega_flip_permuter_w8 (
    .data_in(din8), .ctrl_in(ctl8), .stage_en(en8), .data_out(dout8));

  function automatic int rolf(int i, int w);
    int lg = $clog2(w);
    return ((i << 1) | (i >> (lg - 1))) & (w - 1);
  endfunction

  function automatic int rorf(int i, int w);
    int lg = $clog2(w);
    return (i >> 1) | ((i & 1) << (lg - 1));
  endfunction

  function automatic logic [63:0] swap_pairs(logic [63:0] x, logic [63:0] c, int w);
    logic [63:0] y = x;
    for (int k = 0; k < w/2; k++)
      if (c[k]) begin
        y[2*k]   = x[2*k+1];
        y[2*k+1] = x[2*k];
      end
    return y;
  endfunction

  function automatic logic [63:0] ref_model(logic [63:0] x, logic [63:0] c,
                                            logic [3:0] en, int w);
    logic [63:0] cur = x;
    logic [63:0] tmp;
    logic [63:0] half_c;
    int used = 0;
    if ($countones(en) != 2) return x;
    for (int s = 0; s < 4; s++) begin
      if (en[s]) begin
        half_c = (used == 0) ? c : (c >> (w/2));
        used++;
        tmp = '0;
        if (s < 2) begin
          for (int i = 0; i < w; i++) tmp[rolf(i, w)] = cur[i];
          cur = swap_pairs(tmp, half_c, w);
        end else begin
          cur = swap_pairs(cur, half_c, w);
          for (int i = 0; i < w; i++) tmp[rorf(i, w)] = cur[i];
          cur = tmp;
        end
      end
    end
    return cur;
  endfunction

  function automatic string tag_of(logic [3:0] en, logic [63:0] c);
    if ($countones(en) != 2) return "R1";
    if (c == 0)              return "R2";
    if (en == 4'b0011)       return "R3";
    if (en == 4'b1100)       return "R4";
    return "R5";
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run8(logic [7:0] d, logic [7:0] c, logic [3:0] e);
    @(posedge clk);
    din8 = d; ctl8 = c; en8 = e;
    @(negedge clk);
    check(tag_of(e, {56'd0, c}), {56'd0, dout8},
          ref_model({56'd0, d}, {56'd0, c}, e, 8) & 64'hFF);
  endtask

  task automatic run64(string req, logic [63:0] d, logic [63:0] c, logic [3:0] e);
    @(posedge clk);
    din64 = d; ctl64 = c; en64 = e;
    @(negedge clk);
    check(req, dout64, ref_model(d, c, e, 64));
    check("R6", 64'($countones(dout64)), 64'($countones(d)));
  endtask

  initial begin
    din64 = '0; ctl64 = '0; en64 = '0;
    din8  = '0; ctl8  = '0; en8  = '0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8", dout64, 64'd0);
    check("R8", {56'd0, dout8}, 64'd0);

    for (int e = 0; e < 16; e++)
      for (int c = 0; c < 256; c++)
        for (int b = 0; b < 8; b++)
          run8(8'(1 << b), 8'(c), 4'(e));

    begin
      logic [63:0] lf = 64'h9E37_79B9_7F4A_7C15;
      logic [63:0] cw;
      for (int e = 0; e < 16; e++)
        for (int p = 0; p < 8; p++) begin
          lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
          case (p)
            0: cw = '0;
            1: cw = '1;
            2: cw = 64'hAAAA_AAAA_5555_5555;
            3: cw = 64'h1;
            4: cw = 64'h1 << 32;
            default: cw = lf ^ {lf[31:0], lf[63:32]};
          endcase
          run64(tag_of(4'(e), cw), lf, cw, 4'(e));
          run64(tag_of(4'(e), cw), 64'h1 << (p * 7 + e), cw, 4'(e));
        end
      for (int o = 0; o < 2; o++)
        for (int f = 2; f < 4; f++)
          for (int k = 0; k < 4; k++) begin
            logic [31:0] h = 32'hC3A5_0F1E ^ (32'h1357_9BDF << k);
            logic [3:0]  e = 4'((1 << o) | (1 << f));
            run64("R7", 64'h0123_4567_89AB_CDEF + 64'(k), {h, h}, e);
            check("R7", dout64, din64);
          end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule